// File: doc/BRIEF.md
# Sparse Spanning-Tree Prefix Adder

This block adds two unsigned binary operands and a carry-in. It produces an N-bit sum and a carry-out. A sparse carry tree works out the carry only at the boundary of each 4-bit group. Inside each group, a short ripple chain finishes the sum from that one resolved carry. Doing this keeps the prefix network small, and the long carry path still grows with log2 of the group count.

Each bit forms its own propagate and generate signals. A balanced tree of black prefix cells reduces every 4-bit group to a group generate/propagate pair. A second prefix network then runs across the groups. In that network the carry-in counts as an extra element at the low end, and gray cells are used wherever the propagate is no longer needed. The width is a parameter that must be a multiple of the group size. An optional output register adds one cycle of latency.

Top module: `spt_adder`

## Requirements
- R1: {cout_o, sum_o} equals a_i + b_i + cin_i, taken as unsigned values, for every operand pattern at both 16 and 64 bits.
- R2: cin_i acts as the carry into bit 0. All-ones plus zero with cin_i=1 gives sum 0 and cout 1. Zero plus zero with cin_i=1 gives sum 1.
- R3: A carry made in the top bit of one 4-bit group reaches bit 0 of the next group. For example, 0x000F + 0x0001 = 0x0010, and 0x0FFF + 0x0001 = 0x1000.
- R4: When every bit propagates (a_i = ~b_i), the carry-out and every sum bit depend only on cin_i. cin_i=0 gives all-ones and no carry-out. cin_i=1 gives zero and a carry-out.
- R5: cout_o is 1 exactly when the true sum reaches 2^N. With cout_o=1, sum_o is no greater than a_i. With cout_o=0, sum_o is no less than a_i.
- R6: With OUT_REG=1, the outputs reflect the operands sampled at the previous rising clk_i edge. They hold their old value until the next edge.
- R7: While rst_ni is low, sum_o and cout_o read zero.
- R8: The carry out of each group's ripple chain equals the carry that the tree computes into the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry that travels through every group of the tree. This needs all propagate bits set across the full width. Random operands almost never produce it, because the chance falls as 2^-N. The stimulus reaches it directly by pairing operands with their complement under both carry-in values. It also uses operands that are all-ones within a group, which test each group boundary in turn. Random vectors at 16 and 64 bits then cover mixed generate and kill patterns.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef struct packed {
    logic g;
    logic p;
  } pg_t;

  // Combine a more significant span (hi) with the adjacent lower span (lo).
  function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
    pg_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction
endpackage

// File: rtl/spt_prefix_cell.sv
module spt_prefix_cell
  import spt_pkg::*;
#(
  parameter bit IS_BLACK = 1'b1
) (
  input  pg_t hi_i,
  input  pg_t lo_i,
  output pg_t out_o
);
  pg_t merged;
  assign merged = pg_merge(hi_i, lo_i);

  generate
    if (IS_BLACK) begin : g_black
      assign out_o = merged;
    end else begin : g_gray
      // span already reaches the carry-in: propagate no longer used
      assign out_o = '{g: merged.g, p: 1'b0};
    end
  endgenerate
endmodule

// File: rtl/spt_group_pg.sv
module spt_group_pg
  import spt_pkg::*;
#(
  parameter int GROUP = 4
) (
  input  logic [GROUP-1:0] a_i,
  input  logic [GROUP-1:0] b_i,
  output logic [GROUP-1:0] p_o,
  output logic [GROUP-1:0] g_o,
  output pg_t              grp_o
);
  localparam int LV = $clog2(GROUP);

  pg_t lvl [LV+1][GROUP];

  assign p_o = a_i ^ b_i;
  assign g_o = a_i & b_i;

  generate
    for (genvar j = 0; j < GROUP; j++) begin : g_leaf
      assign lvl[0][j] = '{g: g_o[j], p: p_o[j]};
    end
    for (genvar l = 0; l < LV; l++) begin : g_lvl
      localparam int CNT = GROUP >> (l + 1);
      for (genvar j = 0; j < GROUP; j++) begin : g_node
        if (j < CNT) begin : g_cell
          spt_prefix_cell #(.IS_BLACK(1'b1)) u_cell (
            .hi_i (lvl[l][2*j+1]),
            .lo_i (lvl[l][2*j]),
            .out_o(lvl[l+1][j])
          );
        end else begin : g_idle
          assign lvl[l+1][j] = '{g: 1'b0, p: 1'b0};
        end
      end
    end
  endgenerate

  assign grp_o = lvl[LV][0];
endmodule

// File: rtl/spt_carry_tree.sv
module spt_carry_tree
  import spt_pkg::*;
#(
  parameter int NGRP = 4
) (
  input  pg_t              grp_i [NGRP],
  input  logic             cin_i,
  output logic [NGRP:0]    carry_o
);
  localparam int NEL = NGRP + 1;
  localparam int LV  = $clog2(NEL);

  pg_t node [LV+1][NEL];

  // element 0 is the carry-in, element k is group k-1
  assign node[0][0] = '{g: cin_i, p: 1'b0};

  generate
    for (genvar k = 1; k < NEL; k++) begin : g_in
      assign node[0][k] = grp_i[k-1];
    end
    for (genvar l = 0; l < LV; l++) begin : g_lvl
      localparam int D = 1 << l;
      for (genvar i = 0; i < NEL; i++) begin : g_node
        if (i >= D) begin : g_cell
          spt_prefix_cell #(.IS_BLACK(i >= 2*D)) u_cell (
            .hi_i (node[l][i]),
            .lo_i (node[l][i-D]),
            .out_o(node[l+1][i])
          );
        end else begin : g_pass
          assign node[l+1][i] = node[l][i];
        end
      end
    end
    for (genvar k = 0; k < NEL; k++) begin : g_out
      assign carry_o[k] = node[LV][k].g;
    end
  endgenerate
endmodule

// File: rtl/spt_ripple_seg.sv
module spt_ripple_seg #(
  parameter int GROUP = 4
) (
  input  logic [GROUP-1:0] p_i,
  input  logic [GROUP-1:0] g_i,
  input  logic             c_i,
  output logic [GROUP-1:0] s_o,
  output logic             c_o
);
  logic [GROUP:0] c;
  assign c[0] = c_i;

  generate
    for (genvar j = 0; j < GROUP; j++) begin : g_bit
      assign s_o[j]   = p_i[j] ^ c[j];
      assign c[j+1]   = g_i[j] | (p_i[j] & c[j]);
    end
  endgenerate

  assign c_o = c[GROUP];
endmodule

// File: rtl/spt_adder.sv
module spt_adder
  import spt_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int GROUP   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NGRP = WIDTH / GROUP;

  initial begin
    if (WIDTH % GROUP != 0 || GROUP < 2 || (GROUP & (GROUP - 1)) != 0)
      $error("spt_adder: WIDTH must be a multiple of a power-of-two GROUP");
  end

  logic [WIDTH-1:0] p, g, sum_d;
  pg_t              grp [NGRP];
  logic [NGRP:0]    tree_c;
  logic [NGRP-1:0]  seg_c;
  logic             cout_d;

  generate
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
      spt_group_pg #(.GROUP(GROUP)) u_pg (
        .a_i  (a_i[k*GROUP +: GROUP]),
        .b_i  (b_i[k*GROUP +: GROUP]),
        .p_o  (p[k*GROUP +: GROUP]),
        .g_o  (g[k*GROUP +: GROUP]),
        .grp_o(grp[k])
      );
      spt_ripple_seg #(.GROUP(GROUP)) u_seg (
        .p_i(p[k*GROUP +: GROUP]),
        .g_i(g[k*GROUP +: GROUP]),
        .c_i(tree_c[k]),
        .s_o(sum_d[k*GROUP +: GROUP]),
        .c_o(seg_c[k])
      );
    end
  endgenerate

  spt_carry_tree #(.NGRP(NGRP)) u_tree (
    .grp_i  (grp),
    .cin_i  (cin_i),
    .carry_o(tree_c)
  );

  assign cout_d = tree_c[NGRP];

  // operands matching the current outputs (checker view only)
  logic [WIDTH-1:0] chk_a, chk_b;
  logic             chk_cin;

  generate
    if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sum_o  <= '0;
          cout_o <= 1'b0;
        end else begin
          sum_o  <= sum_d;
          cout_o <= cout_d;
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chk_a   <= '0;
          chk_b   <= '0;
          chk_cin <= 1'b0;
        end else begin
          chk_a   <= a_i;
          chk_b   <= b_i;
          chk_cin <= cin_i;
        end
      end
    end else begin : g_comb
      assign sum_o   = sum_d;
      assign cout_o  = cout_d;
      assign chk_a   = a_i;
      assign chk_b   = b_i;
      assign chk_cin = cin_i;
    end
  endgenerate

  logic chk_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_ok <= 1'b0;
    else         chk_ok <= 1'b1;
  end

  // R1: arithmetic result at the ports
  a_r1_sum_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_ok |-> ({cout_o, sum_o} ==
      ({1'b0, chk_a} + {1'b0, chk_b} + {{WIDTH{1'b0}}, chk_cin})));

  // R4: all-propagate operands pass cin straight to the top
  a_r4_full_propagate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&(a_i ^ b_i)) |-> (cout_d == cin_i && sum_d == {WIDTH{~cin_i}}));

  // R5: carry-out matches wrap of the sum relative to an operand
  a_r5_cout_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_ok |-> (cout_o ? (sum_o <= chk_a) : (sum_o >= chk_a)));

  // R6: outputs only move after an operand change
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_ok && $stable(chk_a) && $stable(chk_b) && $stable(chk_cin))
      |-> ($stable(sum_o) && $stable(cout_o)));

  generate
    for (genvar k = 0; k < NGRP; k++) begin : g_chk
      // R8: local ripple and tree agree at each group boundary
      a_r8_seg_vs_tree: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seg_c[k] == tree_c[k+1]);
    end
  endgenerate
endmodule

// File: tb/spt_adder_bench.sv
module spt_adder_bench;
  localparam int W16 = 16;
  localparam int W64 = 64;
  localparam int NRAND = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W16-1:0] a16 = '0, b16 = '0, s16;
  logic [W64-1:0] a64 = '0, b64 = '0, s64;
  logic c16 = 1'b0, c64 = 1'b0, co16, co64;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  spt_adder #(.WIDTH(W16), .GROUP(4), .OUT_REG(1'b1)) u_spt_adder (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a16), .b_i(b16), .cin_i(c16),
    .sum_o(s16), .cout_o(co16));

  spt_adder #(.WIDTH(W64), .GROUP(4), .OUT_REG(1'b1)) u_spt_adder_w64 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a64), .b_i(b64), .cin_i(c64),
    .sum_o(s64), .cout_o(co64));

  function automatic logic [W16:0] exp16(logic [W16-1:0] a, logic [W16-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{W16{1'b0}}, c};
  endfunction

  function automatic logic [W64:0] exp64(logic [W64-1:0] a, logic [W64-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{W64{1'b0}}, c};
  endfunction

  task automatic chk16(string req, logic [W16:0] act, logic [W16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s w16: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk64(string req, logic [W64:0] act, logic [W64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s w64: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run16(string req, logic [W16-1:0] a, logic [W16-1:0] b, logic c);
    @(negedge clk);
    a16 = a; b16 = b; c16 = c;
    @(negedge clk);
    chk16(req, {co16, s16}, exp16(a, b, c));
  endtask

  task automatic run64(string req, logic [W64-1:0] a, logic [W64-1:0] b, logic c);
    @(negedge clk);
    a64 = a; b64 = b; c64 = c;
    @(negedge clk);
    chk64(req, {co64, s64}, exp64(a, b, c));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W16:0] prev;
    void'($urandom(32'd20141));

    // R7: outputs held at zero under reset despite live operands
    a16 = 16'hFFFF; b16 = 16'h0001; c16 = 1'b1;
    a64 = '1; b64 = 64'd1; c64 = 1'b1;
    repeat (3) @(negedge clk);
    chk16("R7", {co16, s16}, '0);
    chk64("R7", {co64, s64}, '0);
    rst_n = 1'b1;

    // R2: carry-in enters at bit 0
    run16("R2", 16'hFFFF, 16'h0000, 1'b1);
    run16("R2", 16'h0000, 16'h0000, 1'b1);
    run64("R2", '1, '0, 1'b1);
    run64("R2", '0, '0, 1'b1);
    run16("R1", 16'h0000, 16'h0000, 1'b0);

    // R3: carries crossing group boundaries
    run16("R3", 16'h000F, 16'h0001, 1'b0);
    run16("R3", 16'h0FFF, 16'h0001, 1'b0);
    run16("R3", 16'h00F0, 16'h0010, 1'b0);
    run16("R3", 16'h7FFF, 16'h0000, 1'b1);
    for (int k = 0; k < W64 / 4; k++) begin
      run64("R3", (64'h1 << (4 * k + 4)) - 64'h1, 64'h1, 1'b0);
    end

    // R4: every bit propagates
    run16("R4", 16'h5555, 16'hAAAA, 1'b1);
    run16("R4", 16'h5555, 16'hAAAA, 1'b0);
    run16("R4", 16'h1234, 16'hEDCB, 1'b1);
    run64("R4", 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
    run64("R4", 64'hF0F0_F0F0_0F0F_0F0F, 64'h0F0F_0F0F_F0F0_F0F0, 1'b0);

    // R5: carry-out boundary
    run16("R5", 16'hFFFF, 16'hFFFF, 1'b1);
    run16("R5", 16'h8000, 16'h8000, 1'b0);
    run16("R5", 16'h8000, 16'h7FFF, 1'b0);
    run64("R5", '1, '1, 1'b1);
    run64("R5", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);

    // R6: old result visible until the next edge
    run16("R6", 16'h1111, 16'h2222, 1'b0);
    prev = exp16(16'h1111, 16'h2222, 1'b0);
    @(negedge clk);
    a16 = 16'hABCD; b16 = 16'h1357; c16 = 1'b1;
    #1;
    chk16("R6", {co16, s16}, prev);
    @(negedge clk);
    chk16("R6", {co16, s16}, exp16(16'hABCD, 16'h1357, 1'b1));

    // R1 R8: random operands, both widths
    for (int i = 0; i < NRAND; i++) begin
      @(negedge clk);
      a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
      a64 = {$urandom, $urandom}; b64 = {$urandom, $urandom}; c64 = 1'($urandom);
      @(negedge clk);
      chk16("R1", {co16, s16}, exp16(a16, b16, c16));
      chk64("R8", {co64, s64}, exp64(a64, b64, c64));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule